// File: doc/BRIEF.md
# Tag-Matching Multi-Level Operand Bypass

This block chooses the value of one source operand for one execution lane. Each clock, every one of `LANES` execution lanes may broadcast a result together with its destination tag and a valid flag. The block latches these broadcasts and ages them through `DEPTH` levels of registers, one level per clock. `DEPTH` is set equal to the register-file write latency, so any result that has not yet reached the register file is still held here.

Selection needs no control input. The operand's source tag is compared against the tag of every valid held result. A matching entry supplies the operand value. When nothing matches, the value read from the payload or register file is passed through unchanged. The candidates per operand are `LANES * DEPTH` held results plus the register-file value. The youngest level has priority, so a newer producer of a reused tag wins over an older one.

Internally, the choice is an enumerated source kind with two states. `SRC_FILE` is entered whenever no held entry matches. `SRC_FWD` is entered whenever at least one entry matches. Both transitions are combinational, taken on every change of the source tag or of the held results. The state is not a register.

Top module: `opnd_bypass`

## Requirements
- R1: While `rst_n` is low, every held entry is cleared. After reset, and before any result is accepted, `o_val` equals `i_rf_val` and `o_bypass` is 0 for any source tag.
- R2: A lane result with its valid bit set at a rising edge can be matched right after that edge, at level 0.
- R3: Held results move one level per clock. A result accepted at edge e can be matched after each of edges e through e+DEPTH-1. After edge e+DEPTH it is gone.
- R4: A lane result presented with its valid bit clear is never stored, and it never matches.
- R5: When no valid held entry carries a tag equal to `i_src_tag`, `o_val` equals `i_rf_val` and `o_bypass` is 0.
- R6: When entries at several levels match, the value from the lowest-numbered (youngest) level is forwarded.
- R7: When several lanes match within the same level, the value from the lowest-numbered lane is forwarded.
- R8: When a match exists, `o_bypass` is 1 and `o_val` equals the data of the entry chosen by R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all level registers update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears every held valid bit |
| i_res_vld | input | LANES | Per-lane result valid; bit k belongs to lane k |
| i_res_tag | input | LANES x TAG_W | Per-lane destination tag |
| i_res_data | input | LANES x DATA_W | Per-lane result value |
| i_src_tag | input | TAG_W | Source tag of the operand being selected |
| i_rf_val | input | DATA_W | Operand value read from payload or register file |
| o_val | output | DATA_W | Selected operand value (combinational) |
| o_bypass | output | 1 | 1 when the value came from a held result |

## Verification
The bench builds the block with four lanes, three levels, 32-bit data and 7-bit tags. Three levels is enough to observe a result aging through every level and then retiring. Four lanes allow same-level lane conflicts and matches across several levels in one cycle. Random tags are drawn from only six values, so tag collisions across lanes and levels happen often. This exercises both the level-priority rule and the lane-priority rule alongside the fallback path.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

    typedef enum logic {
        SRC_FILE = 1'b0,
        SRC_FWD  = 1'b1
    } src_kind_e;

endpackage

// File: rtl/opnd_bypass_stage.sv
module opnd_bypass_stage #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              d_vld,
    input  logic [LANES-1:0][TAG_W-1:0]   d_tag,
    input  logic [LANES-1:0][DATA_W-1:0]  d_data,
    output logic [LANES-1:0]              q_vld,
    output logic [LANES-1:0][TAG_W-1:0]   q_tag,
    output logic [LANES-1:0][DATA_W-1:0]  q_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= '0;
        end else begin
            q_vld <= d_vld;
        end
    end

    always_ff @(posedge clk) begin
        q_tag  <= d_tag;
        q_data <= d_data;
    end

endmodule

// File: rtl/opnd_bypass_match.sv
module opnd_bypass_match #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic [LANES-1:0]              e_vld,
    input  logic [LANES-1:0][TAG_W-1:0]   e_tag,
    input  logic [LANES-1:0][DATA_W-1:0]  e_data,
    input  logic [TAG_W-1:0]              src_tag,
    output logic                          hit,
    output logic [DATA_W-1:0]             hit_data
);

    logic [LANES-1:0] lane_eq;

    for (genvar k = 0; k < LANES; k++) begin : g_cmp
        assign lane_eq[k] = e_vld[k] && (e_tag[k] == src_tag);
    end

    // Walk from the top lane down so the lowest matching lane is written last.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (lane_eq[k]) begin
                hit      = 1'b1;
                hit_data = e_data[k];
            end
        end
    end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
    import opnd_bypass_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DEPTH  = 3,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              i_res_vld,
    input  logic [LANES-1:0][TAG_W-1:0]   i_res_tag,
    input  logic [LANES-1:0][DATA_W-1:0]  i_res_data,
    input  logic [TAG_W-1:0]              i_src_tag,
    input  logic [DATA_W-1:0]             i_rf_val,
    output logic [DATA_W-1:0]             o_val,
    output logic                          o_bypass
);

    localparam int CANDIDATES = LANES * DEPTH + 1;

    logic [DEPTH-1:0][LANES-1:0]              lv_vld;
    logic [DEPTH-1:0][LANES-1:0][TAG_W-1:0]   lv_tag;
    logic [DEPTH-1:0][LANES-1:0][DATA_W-1:0]  lv_data;
    logic [DEPTH-1:0]                         lv_hit;
    logic [DEPTH-1:0][DATA_W-1:0]             lv_hit_data;

    src_kind_e         sel_kind;
    logic [DATA_W-1:0] fwd_val;

    for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
        if (l == 0) begin : g_head
            opnd_bypass_stage #(.LANES(LANES), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_vld  (i_res_vld),
                .d_tag  (i_res_tag),
                .d_data (i_res_data),
                .q_vld  (lv_vld[l]),
                .q_tag  (lv_tag[l]),
                .q_data (lv_data[l])
            );
        end else begin : g_tail
            opnd_bypass_stage #(.LANES(LANES), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_vld  (lv_vld[l-1]),
                .d_tag  (lv_tag[l-1]),
                .d_data (lv_data[l-1]),
                .q_vld  (lv_vld[l]),
                .q_tag  (lv_tag[l]),
                .q_data (lv_data[l])
            );
        end

        opnd_bypass_match #(.LANES(LANES), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_match (
            .e_vld    (lv_vld[l]),
            .e_tag    (lv_tag[l]),
            .e_data   (lv_data[l]),
            .src_tag  (i_src_tag),
            .hit      (lv_hit[l]),
            .hit_data (lv_hit_data[l])
        );
    end

    // Oldest level first, youngest last: level 0 has the final say.
    always_comb begin
        sel_kind = SRC_FILE;
        fwd_val  = '0;
        for (int l = DEPTH - 1; l >= 0; l--) begin
            if (lv_hit[l]) begin
                sel_kind = SRC_FWD;
                fwd_val  = lv_hit_data[l];
            end
        end
    end

    always_comb begin
        unique case (sel_kind)
            SRC_FWD: begin
                o_val    = fwd_val;
                o_bypass = 1'b1;
            end
            SRC_FILE: begin
                o_val    = i_rf_val;
                o_bypass = 1'b0;
            end
            default: begin
                o_val    = i_rf_val;
                o_bypass = 1'b0;
            end
        endcase
    end

    logic unused_cnt;
    assign unused_cnt = (CANDIDATES == 0);

endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
    parameter int LANES  = 4,
    parameter int DEPTH  = 3,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 7
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [LANES-1:0]                     i_res_vld,
    input logic [DATA_W-1:0]                    i_rf_val,
    input logic [DATA_W-1:0]                    o_val,
    input logic                                 o_bypass,
    input logic [DEPTH-1:0][LANES-1:0]          lv_vld,
    input logic [DEPTH-1:0][LANES-1:0][TAG_W-1:0] lv_tag
);

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> (lv_vld == '0)); // R1

    AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lv_vld[0] == $past(i_res_vld))); // R2

    AST_INVALID_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((lv_vld[0] & ~$past(i_res_vld)) == '0)); // R4

    AST_FALLBACK_RF: assert property (@(posedge clk) disable iff (!rst_n)
        !o_bypass |-> (o_val == i_rf_val)); // R5

    if (DEPTH > 1) begin : g_shift
        AST_LEVEL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (lv_vld[DEPTH-1:1] == $past(lv_vld[DEPTH-2:0]))); // R3
        AST_TAG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (lv_tag[DEPTH-1:1] == $past(lv_tag[DEPTH-2:0]))); // R3
    end

endmodule

bind opnd_bypass opnd_bypass_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_res_vld (i_res_vld),
    .i_rf_val  (i_rf_val),
    .o_val     (o_val),
    .o_bypass  (o_bypass),
    .lv_vld    (lv_vld),
    .lv_tag    (lv_tag)
);

// File: tb/opnd_bypass_test.sv
module opnd_bypass_test;

    localparam int LANES  = 4;
    localparam int DEPTH  = 3;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 7;
    localparam time CLK_PERIOD = 10;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [LANES-1:0]              res_vld = '0;
    logic [LANES-1:0][TAG_W-1:0]   res_tag = '0;
    logic [LANES-1:0][DATA_W-1:0]  res_data = '0;
    logic [TAG_W-1:0]              src_tag = '0;
    logic [DATA_W-1:0]             rf_val = '0;
    logic [DATA_W-1:0]             o_val;
    logic                          o_bypass;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    opnd_bypass #(.LANES(LANES), .DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_res_vld  (res_vld),
        .i_res_tag  (res_tag),
        .i_res_data (res_data),
        .i_src_tag  (src_tag),
        .i_rf_val   (rf_val),
        .o_val      (o_val),
        .o_bypass   (o_bypass)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference history built from the requirements: index 0 is the youngest level.
    bit                m_vld [DEPTH][LANES];
    logic [TAG_W-1:0]  m_tag [DEPTH][LANES];
    logic [DATA_W-1:0] m_data[DEPTH][LANES];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < DEPTH; l++)
                for (int k = 0; k < LANES; k++) m_vld[l][k] = 1'b0;
        end else begin
            for (int l = DEPTH - 1; l > 0; l--)
                for (int k = 0; k < LANES; k++) begin
                    m_vld[l][k]  = m_vld[l-1][k];
                    m_tag[l][k]  = m_tag[l-1][k];
                    m_data[l][k] = m_data[l-1][k];
                end
            for (int k = 0; k < LANES; k++) begin
                m_vld[0][k]  = res_vld[k];
                m_tag[0][k]  = res_tag[k];
                m_data[0][k] = res_data[k];
            end
        end
    end

    function automatic logic [DATA_W:0] model_pick(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] rf);
        for (int l = 0; l < DEPTH; l++)
            for (int k = 0; k < LANES; k++)
                if (m_vld[l][k] && m_tag[l][k] == t) return {1'b1, m_data[l][k]};
        return {1'b0, rf};
    endfunction

    task automatic check(input string req, input logic [DATA_W-1:0] exp_val, input logic exp_byp);
        n_chk++;
        if (o_val !== exp_val || o_bypass !== exp_byp) begin
            n_fail++;
            $display("FAIL %s: got val=%h byp=%b, expected val=%h byp=%b", req, o_val, o_bypass, exp_val, exp_byp);
        end
    endtask

    task automatic clear_push();
        res_vld = '0;
        res_tag = '0;
        res_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_push();
    endtask

    task automatic probe(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] rf);
        src_tag = t;
        rf_val  = rf;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W:0] exp;
        void'($urandom(32'h1b5e_2c07));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        probe(7'd5, 32'h1111_0000);
        check("R1", 32'h1111_0000, 1'b0);

        // R2: accepted result visible at level 0
        res_vld[2] = 1'b1; res_tag[2] = 7'd9; res_data[2] = 32'hAAAA_0009;
        step();
        probe(7'd9, 32'h0);
        check("R2", 32'hAAAA_0009, 1'b1);
        // R3: still held through the last level, then retired
        step(); probe(7'd9, 32'h0); check("R3", 32'hAAAA_0009, 1'b1);
        step(); probe(7'd9, 32'h0); check("R3", 32'hAAAA_0009, 1'b1);
        step(); probe(7'd9, 32'h2222_0009); check("R3", 32'h2222_0009, 1'b0);

        // R4: invalid result never matches
        res_vld[1] = 1'b0; res_tag[1] = 7'd12; res_data[1] = 32'hBAD0_0012;
        step(); probe(7'd12, 32'h3333_0012); check("R4", 32'h3333_0012, 1'b0);

        // R6: youngest level wins
        res_vld[0] = 1'b1; res_tag[0] = 7'd20; res_data[0] = 32'hB000_0020;
        step();
        res_vld[3] = 1'b1; res_tag[3] = 7'd20; res_data[3] = 32'hC000_0020;
        step(); probe(7'd20, 32'h0); check("R6", 32'hC000_0020, 1'b1);

        // R7: lowest lane wins within a level
        res_vld[1] = 1'b1; res_tag[1] = 7'd30; res_data[1] = 32'hD000_0030;
        res_vld[3] = 1'b1; res_tag[3] = 7'd30; res_data[3] = 32'hE000_0030;
        step(); probe(7'd30, 32'h0); check("R7", 32'hD000_0030, 1'b1);

        // R5: unrelated tag falls back
        probe(7'd77, 32'h4444_0077); check("R5", 32'h4444_0077, 1'b0);

        // R8 / R5: random traffic with a narrow tag range
        for (int c = 0; c < 3000; c++) begin
            for (int k = 0; k < LANES; k++) begin
                res_vld[k]  = ($urandom % 3) != 0;
                res_tag[k]  = TAG_W'($urandom % 6);
                res_data[k] = $urandom;
            end
            @(posedge clk);
            @(negedge clk);
            probe(TAG_W'($urandom % 7), $urandom);
            exp = model_pick(src_tag, rf_val);
            if (exp[DATA_W]) check("R8", exp[DATA_W-1:0], 1'b1);
            else             check("R5", exp[DATA_W-1:0], 1'b0);
        end

        // R1: reset in mid-run clears all levels
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        probe(7'd3, 32'h5555_0003); check("R1", 32'h5555_0003, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule